// File: doc/BRIEF.md
# LIN Remote Wake Filter

This block looks at the receive level of a LIN bus while the transceiver sits in a low-power mode. It decides whether that level shows a genuine remote wake. A wake counts only when the bus drops to dominant, stays dominant for at least a programmed number of time ticks, and then returns to recessive. The block answers with a one-cycle wake pulse on that return edge. A dominant level on its own never wakes the node. A bus held shorted to dominant therefore wakes the node only once the short clears.

The mode controller drives the arm input high for as long as a low-power mode is active. An external divider supplies single-cycle ticks; with a 10 µs tick, the default of 9 ticks gives a 90 µs filter. The raw bus level passes through a synchronizer before the filter uses it. After one wake, the block stays quiet until the arm input has been dropped and raised again.

Top module: `lin_wake_filter`

## Requirements
- R1: After reset, wake_o is low.
- R2: With arm_i high, a dominant level (bus_rx_i = 0) that lasts for at least FILT_TICKS ticks and is then followed by recessive (bus_rx_i = 1) produces exactly one wake_o pulse, one clock wide.
- R3: A dominant pulse that lasts only FILT_TICKS-1 ticks before going recessive produces no wake.
- R4: No wake is issued while the bus stays dominant, however many ticks pass. The wake follows the return to recessive.
- R5: While arm_i is low, no pattern on the bus produces a wake.
- R6: After a wake, further valid patterns produce no wake until arm_i has gone low and then high again.
- R7: If arm_i rises while the bus is already dominant (a shorted bus), the dominant time counts from arming, and the later release to recessive produces a wake.
- R8: A recessive level that arrives before the threshold clears the dominant time. Two short pulses whose tick counts together exceed the threshold give no wake.
- R9: Dropping arm_i during a dominant pulse discards that pulse, and no wake follows its release.
- R10: wake_o goes high in the third clock cycle after the recessive level appears at bus_rx_i (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rx_i | input | 1 | Raw bus receive level, 1 = recessive, 0 = dominant |
| arm_i | input | 1 | High while a low-power mode allows wake detection |
| tick_i | input | 1 | One-cycle timing tick for the dominant filter |
| wake_o | output | 1 | One-cycle remote wake request |

## Verification
The assertions assume that arm_i and tick_i are synchronous to clk and that tick_i is a single-cycle strobe. Only bus_rx_i may be asynchronous. The bench drives every input on the falling clock edge. It spaces the ticks at least one idle cycle apart and issues them only after a new bus level has had time to pass the synchronizer. As a result, the number of ticks seen during each dominant pulse is exactly the number the test intends. The pulse lengths sit on either side of the threshold, at FILT_TICKS-1 and FILT_TICKS, and around the arm transitions.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HUNT = 2'd1,
    ST_DOM  = 2'd2,
    ST_DONE = 2'd3
  } lwf_state_e;
endpackage

// File: rtl/lwf_sync.sv
module lwf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lwf_dom_timer.sv
module lwf_dom_timer #(
  parameter int FILT_TICKS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic sat_o
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != LIMIT));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sat_o = (cnt_q == LIMIT);

  p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  p_cnt_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/lwf_wake_fsm.sv
module lwf_wake_fsm
  import lwf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic rx_s_i,
  input  logic sat_i,
  output logic timer_clr_o,
  output logic wake_o
);
  lwf_state_e state_q, state_d;
  logic       wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (arm_i) state_d = rx_s_i ? ST_HUNT : ST_DOM;
      ST_HUNT: if (!arm_i) state_d = ST_OFF;
               else if (!rx_s_i) state_d = ST_DOM;
      ST_DOM:  if (!arm_i) state_d = ST_OFF;
               else if (rx_s_i) state_d = sat_i ? ST_DONE : ST_HUNT;
      ST_DONE: if (!arm_i) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
    wake_d      = arm_i && (state_q == ST_DOM) && rx_s_i && sat_i;
    timer_clr_o = (state_q != ST_DOM) || rx_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign wake_o = wake_q;

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  p_no_wake_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !wake_o);
  p_done_after_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o && arm_i |=> (state_q == ST_DONE) && !wake_o);
  p_wake_on_recessive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(rx_s_i));
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int FILT_TICKS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rx_i,
  input  logic arm_i,
  input  logic tick_i,
  output logic wake_o
);
  logic rx_s;
  logic sat;
  logic timer_clr;

  lwf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (bus_rx_i),
    .q_o   (rx_s)
  );

  lwf_dom_timer #(.FILT_TICKS(FILT_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (timer_clr),
    .inc_i (tick_i && !rx_s),
    .sat_o (sat)
  );

  lwf_wake_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .rx_s_i      (rx_s),
    .sat_i       (sat),
    .timer_clr_o (timer_clr),
    .wake_o      (wake_o)
  );

  p_wake_needs_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(sat));
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wake_o);
endmodule

// File: tb/lin_wake_filter_tb_top.sv
module lin_wake_filter_tb_top;
  localparam int FT = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rx = 1'b1;
  logic arm = 1'b0;
  logic tick = 1'b0;
  logic wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lin_wake_filter #(.FILT_TICKS(FT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rx_i(bus_rx),
    .arm_i(arm), .tick_i(tick), .wake_o(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); if (wake) seen++;
      tick = 1'b0; step(); if (wake) seen++;
    end
  endtask

  task automatic go_dom(output int seen);
    seen = 0;
    bus_rx = 1'b0;
    for (int i = 0; i < 4; i++) begin step(); if (wake) seen++; end
  endtask

  task automatic release_bus(output int cnt, output int first);
    cnt = 0; first = -1;
    bus_rx = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      step();
      if (wake) begin cnt++; if (first < 0) first = i; end
    end
  endtask

  task automatic pulse(input int n, output int during, output int cnt, output int first);
    int a, b;
    go_dom(a); ticks(n, b);
    during = a + b;
    release_bus(cnt, first);
  endtask

  task automatic rearm();
    arm = 1'b0; step(); step(); arm = 1'b1; step(); step();
  endtask

  task automatic t_reset();
    chk(wake == 1'b0, "R1", wake, 0);
  endtask

  task automatic t_valid();
    int d, c, f;
    rearm();
    pulse(FT, d, c, f);
    chk(d == 0, "R4", d, 0);
    chk(c == 1, "R2", c, 1);
    chk(f == 3, "R10", f, 3);
  endtask

  task automatic t_short();
    int d, c, f;
    rearm();
    pulse(FT - 1, d, c, f);
    chk(c == 0, "R3", c, 0);
  endtask

  task automatic t_split();
    int d, c, f;
    rearm();
    pulse(FT - 2, d, c, f);
    pulse(FT - 2, d, c, f);
    chk(c == 0, "R8", c, 0);
    pulse(FT, d, c, f);
    chk(c == 1, "R8", c, 1);
  endtask

  task automatic t_long_hold();
    int d, c, f;
    rearm();
    pulse(FT * 4, d, c, f);
    chk(d == 0, "R4", d, 0);
    chk(c == 1, "R4", c, 1);
  endtask

  task automatic t_disarmed();
    int d, c, f;
    arm = 1'b0; step(); step();
    pulse(FT + 2, d, c, f);
    chk(d + c == 0, "R5", d + c, 0);
  endtask

  task automatic t_no_rewake();
    int d, c, f;
    rearm();
    pulse(FT, d, c, f);
    chk(c == 1, "R6", c, 1);
    pulse(FT + 1, d, c, f);
    chk(c == 0, "R6", c, 0);
    rearm();
    pulse(FT, d, c, f);
    chk(c == 1, "R6", c, 1);
  endtask

  task automatic t_shorted();
    int d, e, c, f;
    arm = 1'b0; step();
    go_dom(d);
    arm = 1'b1; step(); step();
    ticks(FT, e);
    chk(d + e == 0, "R7", d + e, 0);
    release_bus(c, f);
    chk(c == 1, "R7", c, 1);
    chk(f == 3, "R10", f, 3);
  endtask

  task automatic t_arm_drop();
    int d, e, c, f;
    rearm();
    go_dom(d); ticks(FT + 1, e);
    arm = 1'b0; step(); step();
    arm = 1'b1; step(); step();
    release_bus(c, f);
    chk(c == 0, "R9", c, 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_valid();
    t_short();
    t_split();
    t_long_hold();
    t_disarmed();
    t_no_rewake();
    t_shorted();
    t_arm_drop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule